// File: doc/BRIEF.md
# Accelerator Port Bridge

The bridge connects an in-order host pipeline to a spatial compute fabric through a set of numbered input ports and a set of numbered output ports. Every port owns a small FIFO. The host pushes operands into input ports with a send request. A single send may carry one operand or two. The fabric drains each input FIFO over its own valid/ready stream. Results travel the other way. The fabric fills each output FIFO over a valid/ready stream, and the host removes them with a receive request. A receive takes one value for a register write, or two values for a store, where the first value is the data and the second is the memory address.

The host side has no handshake. Instead, a request that cannot complete right away raises a stall output. A send stalls when a target input FIFO lacks room. A receive stalls when a source output FIFO lacks data. A stalled request changes no FIFO, and the pipeline may hold it or withdraw it. On the fabric streams, a beat transfers on a rising clock edge where valid and ready are both high. A fabric input stream shows valid whenever its FIFO holds data. A fabric output stream shows ready whenever its FIFO is not full, even if the host pops that FIFO in the same cycle.

Top module: `accel_port_bridge`

## Requirements
- R1: After reset every FIFO is empty: all `fab_in_valid` bits are 0, all `fab_out_ready` bits are 1, and no stall is raised while no request is present.
- R2: A send with `send_dual`=0 to input port p (p < NUM_IN) pushes only `send_data_a`. Values leave on `fab_in_data` slice p, bits [p*64 +: 64], in the order they were sent, and one value leaves per cycle while `fab_in_ready[p]` is high.
- R3: A send with `send_dual`=1 to two different in-range ports pushes A into `send_port_a` and B into `send_port_b` in the same edge. Either both are pushed or neither is.
- R4: `send_stall` is high, combinationally, whenever a send targets an in-range input FIFO that already holds 4 entries. A fabric pop in the same cycle does not clear the stall, and a stalled send pushes nothing.
- R5: A dual send whose two in-range ports are equal needs at least 2 free entries in that FIFO, else it stalls. When accepted, A is queued ahead of B.
- R6: `recv_stall` is high whenever a receive reads an in-range output FIFO that is empty. A stalled receive pops nothing and raises neither `rd_wen` nor `st_en`.
- R7: A receive with `recv_pair`=0 that does not stall raises `rd_wen` in the same cycle. It drives the head of output FIFO `recv_port_a` on `rd_data` and echoes `recv_tag` on `rd_tag`, then pops that entry at the edge.
- R8: A receive with `recv_pair`=1 that does not stall raises `st_en` instead of `rd_wen`. `rd_data` carries the head of port A (store data) and `st_addr` carries the head of port B (store address), and both are popped. When A and B name the same port, that FIFO must hold 2 entries. The older entry is the data and the next one is the address.
- R9: Port addresses are 5 bits wide. A send operand aimed at an address ≥ NUM_IN is discarded and never stalls. A receive operand read from an address ≥ NUM_OUT returns zero and never stalls.
- R10: Each FIFO holds 4 entries. `fab_out_ready[p]` is low exactly while output FIFO p holds 4 entries. A push and a pop may occur on one FIFO in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| send_valid | input | 1 | Send request present |
| send_dual | input | 1 | 1: also send operand B |
| send_port_a | input | 5 | Input port for operand A |
| send_port_b | input | 5 | Input port for operand B |
| send_data_a | input | 64 | Operand A |
| send_data_b | input | 64 | Operand B |
| send_stall | output | 1 | Send cannot complete this cycle |
| recv_valid | input | 1 | Receive request present |
| recv_pair | input | 1 | 1: store-style receive of data and address |
| recv_port_a | input | 5 | Output port for the value (store data) |
| recv_port_b | input | 5 | Output port for the store address |
| recv_tag | input | 5 | Destination register tag |
| recv_stall | output | 1 | Receive cannot complete this cycle |
| rd_wen | output | 1 | Register write enable |
| rd_tag | output | 5 | Register tag for the write |
| rd_data | output | 64 | Received value or store data |
| st_en | output | 1 | Store pair delivered |
| st_addr | output | 64 | Store address |
| fab_in_valid | output | NUM_IN | Input FIFO p holds data |
| fab_in_ready | input | NUM_IN | Fabric takes the head of input FIFO p |
| fab_in_data | output | NUM_IN*64 | Head of each input FIFO |
| fab_out_valid | input | NUM_OUT | Fabric offers a result on port p |
| fab_out_ready | output | NUM_OUT | Output FIFO p has room |
| fab_out_data | input | NUM_OUT*64 | Fabric result per output port |

## Verification
The hardest case to reach is a dual send to one port whose FIFO holds exactly three entries. The same applies to a same-port store receive against a FIFO holding exactly one entry. Both need a FIFO held at a chosen fill level while the other side is quiet. To get there, the stimulus runs in phases. In one phase the fabric drains nothing and sends use only four port numbers. In another phase the fabric fills output FIFOs while receives are paused. Then receives resume with pair requests mixed in and with addresses past the last port. The bench model predicts every stall and every value on each cycle.

// File: rtl/xpb_pkg.sv
package xpb_pkg;
  localparam int DATA_W  = 64;
  localparam int PORT_AW = 5;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [PORT_AW-1:0] port_t;
endpackage

// File: rtl/xpb_fifo.sv
module xpb_fifo
  import xpb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] push_n,
  input  word_t      push_d0,
  input  word_t      push_d1,
  input  logic [1:0] pop_n,
  output word_t      head0,
  output word_t      head1,
  output logic       full,
  output logic       empty,
  output logic       room2,
  output logic       has2
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  word_t          mem [DEPTH];
  logic [PW-1:0]  rd_ptr, wr_ptr;
  logic [CW-1:0]  count, count_nxt, free_cnt;
  logic           full_q, empty_q;

  assign count_nxt = count + CW'(push_n) - CW'(pop_n);
  assign free_cnt  = FULL_C - count;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wr_ptr] <= push_d0;
    if (push_n == 2'd2) mem[wr_ptr + PW'(1)] <= push_d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wr_ptr  <= wr_ptr + PW'(push_n);
      rd_ptr  <= rd_ptr + PW'(pop_n);
      count   <= count_nxt;
      full_q  <= (count_nxt == FULL_C);
      empty_q <= (count_nxt == '0);
    end
  end

  assign head0 = mem[rd_ptr];
  assign head1 = mem[rd_ptr + PW'(1)];
  assign full  = full_q;
  assign empty = empty_q;
  assign room2 = (count + CW'(2)) <= FULL_C;
  assign has2  = count >= CW'(2);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(push_n) <= free_cnt);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= count);

  // R2
  fill_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && push_n != 2'd0) |=> !empty_q);

  // R10
  flag_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q == (count == FULL_C)) && (empty_q == (count == '0)));
endmodule

// File: rtl/xpb_send_steer.sv
module xpb_send_steer
  import xpb_pkg::*;
#(
  parameter int NUM_IN = 8
) (
  input  logic                    send_valid,
  input  logic                    send_dual,
  input  port_t                   port_a,
  input  port_t                   port_b,
  input  word_t                   data_a,
  input  word_t                   data_b,
  input  logic [NUM_IN-1:0]       fifo_full,
  input  logic [NUM_IN-1:0]       fifo_room2,
  output logic                    stall,
  output logic [NUM_IN-1:0][1:0]  push_n,
  output word_t [NUM_IN-1:0]      push_d0,
  output word_t [NUM_IN-1:0]      push_d1
);
  logic a_ok, b_on, same, room_ok, go;

  always_comb begin
    a_ok    = int'(port_a) < NUM_IN;
    b_on    = send_dual && (int'(port_b) < NUM_IN);
    same    = a_ok && b_on && (port_a == port_b);
    room_ok = 1'b1;
    for (int i = 0; i < NUM_IN; i++) begin
      if (same && port_a == PORT_AW'(i)) begin
        room_ok = room_ok & fifo_room2[i];
      end else begin
        if (a_ok && port_a == PORT_AW'(i)) room_ok = room_ok & ~fifo_full[i];
        if (b_on && port_b == PORT_AW'(i)) room_ok = room_ok & ~fifo_full[i];
      end
    end
    go    = send_valid && room_ok;
    stall = send_valid && !room_ok;
  end

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    logic hit_a, hit_b;
    assign hit_a      = go && a_ok && (port_a == PORT_AW'(g));
    assign hit_b      = go && b_on && (port_b == PORT_AW'(g));
    assign push_n[g]  = {1'b0, hit_a} + {1'b0, hit_b};
    assign push_d0[g] = hit_a ? data_a : data_b;
    assign push_d1[g] = data_b;
  end
endmodule

// File: rtl/xpb_recv_steer.sv
module xpb_recv_steer
  import xpb_pkg::*;
#(
  parameter int NUM_OUT = 8
) (
  input  logic                    recv_valid,
  input  logic                    recv_pair,
  input  port_t                   port_a,
  input  port_t                   port_b,
  input  word_t [NUM_OUT-1:0]     head0,
  input  word_t [NUM_OUT-1:0]     head1,
  input  logic [NUM_OUT-1:0]      fifo_empty,
  input  logic [NUM_OUT-1:0]      fifo_has2,
  output logic                    stall,
  output logic [NUM_OUT-1:0][1:0] pop_n,
  output logic                    wen,
  output logic                    st_en,
  output word_t                   data,
  output word_t                   addr
);
  logic a_ok, b_on, same, avail, go;

  always_comb begin
    a_ok  = int'(port_a) < NUM_OUT;
    b_on  = recv_pair && (int'(port_b) < NUM_OUT);
    same  = a_ok && b_on && (port_a == port_b);
    avail = 1'b1;
    data  = '0;
    addr  = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      if (a_ok && port_a == PORT_AW'(o)) data = head0[o];
      if (b_on && port_b == PORT_AW'(o)) addr = same ? head1[o] : head0[o];
      if (same && port_a == PORT_AW'(o)) begin
        avail = avail & fifo_has2[o];
      end else begin
        if (a_ok && port_a == PORT_AW'(o)) avail = avail & ~fifo_empty[o];
        if (b_on && port_b == PORT_AW'(o)) avail = avail & ~fifo_empty[o];
      end
    end
    go    = recv_valid && avail;
    stall = recv_valid && !avail;
    wen   = go && !recv_pair;
    st_en = go && recv_pair;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_lane
    logic hit_a, hit_b;
    assign hit_a    = go && a_ok && (port_a == PORT_AW'(g));
    assign hit_b    = go && b_on && (port_b == PORT_AW'(g));
    assign pop_n[g] = {1'b0, hit_a} + {1'b0, hit_b};
  end
endmodule

// File: rtl/accel_port_bridge.sv
module accel_port_bridge
  import xpb_pkg::*;
#(
  parameter int NUM_IN  = 8,
  parameter int NUM_OUT = 8,
  parameter int DEPTH   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        send_valid,
  input  logic                        send_dual,
  input  logic [PORT_AW-1:0]          send_port_a,
  input  logic [PORT_AW-1:0]          send_port_b,
  input  logic [DATA_W-1:0]           send_data_a,
  input  logic [DATA_W-1:0]           send_data_b,
  output logic                        send_stall,
  input  logic                        recv_valid,
  input  logic                        recv_pair,
  input  logic [PORT_AW-1:0]          recv_port_a,
  input  logic [PORT_AW-1:0]          recv_port_b,
  input  logic [PORT_AW-1:0]          recv_tag,
  output logic                        recv_stall,
  output logic                        rd_wen,
  output logic [PORT_AW-1:0]          rd_tag,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        st_en,
  output logic [DATA_W-1:0]           st_addr,
  output logic [NUM_IN-1:0]           fab_in_valid,
  input  logic [NUM_IN-1:0]           fab_in_ready,
  output logic [NUM_IN*DATA_W-1:0]    fab_in_data,
  input  logic [NUM_OUT-1:0]          fab_out_valid,
  output logic [NUM_OUT-1:0]          fab_out_ready,
  input  logic [NUM_OUT*DATA_W-1:0]   fab_out_data
);
  logic [NUM_IN-1:0][1:0]   in_push_n;
  word_t [NUM_IN-1:0]       in_push_d0, in_push_d1;
  logic [NUM_IN-1:0]        in_full, in_empty, in_room2;
  logic [NUM_OUT-1:0][1:0]  out_pop_n;
  word_t [NUM_OUT-1:0]      out_head0, out_head1;
  logic [NUM_OUT-1:0]       out_full, out_empty, out_has2;

  xpb_send_steer #(.NUM_IN(NUM_IN)) u_send (
    .send_valid (send_valid),
    .send_dual  (send_dual),
    .port_a     (send_port_a),
    .port_b     (send_port_b),
    .data_a     (send_data_a),
    .data_b     (send_data_b),
    .fifo_full  (in_full),
    .fifo_room2 (in_room2),
    .stall      (send_stall),
    .push_n     (in_push_n),
    .push_d0    (in_push_d0),
    .push_d1    (in_push_d1)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    word_t      head0_w;
    word_t      unused_head1;
    logic       unused_has2;
    logic [1:0] pop_w;

    assign pop_w = {1'b0, fab_in_ready[i] & ~in_empty[i]};

    xpb_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_n  (in_push_n[i]),
      .push_d0 (in_push_d0[i]),
      .push_d1 (in_push_d1[i]),
      .pop_n   (pop_w),
      .head0   (head0_w),
      .head1   (unused_head1),
      .full    (in_full[i]),
      .empty   (in_empty[i]),
      .room2   (in_room2[i]),
      .has2    (unused_has2)
    );

    assign fab_in_valid[i]                   = ~in_empty[i];
    assign fab_in_data[i*DATA_W +: DATA_W]   = head0_w;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic       unused_room2;
    logic [1:0] push_w;

    assign push_w = {1'b0, fab_out_valid[o] & ~out_full[o]};

    xpb_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_n  (push_w),
      .push_d0 (fab_out_data[o*DATA_W +: DATA_W]),
      .push_d1 ('0),
      .pop_n   (out_pop_n[o]),
      .head0   (out_head0[o]),
      .head1   (out_head1[o]),
      .full    (out_full[o]),
      .empty   (out_empty[o]),
      .room2   (unused_room2),
      .has2    (out_has2[o])
    );

    assign fab_out_ready[o] = ~out_full[o];
  end

  xpb_recv_steer #(.NUM_OUT(NUM_OUT)) u_recv (
    .recv_valid (recv_valid),
    .recv_pair  (recv_pair),
    .port_a     (recv_port_a),
    .port_b     (recv_port_b),
    .head0      (out_head0),
    .head1      (out_head1),
    .fifo_empty (out_empty),
    .fifo_has2  (out_has2),
    .stall      (recv_stall),
    .pop_n      (out_pop_n),
    .wen        (rd_wen),
    .st_en      (st_en),
    .data       (rd_data),
    .addr       (st_addr)
  );

  assign rd_tag = recv_tag;

  // R8
  recv_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_wen && st_en) && !((rd_wen || st_en) && recv_stall));
endmodule

// File: tb/accel_port_bridge_bench.sv
module accel_port_bridge_bench;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam int D  = 4;
  localparam int W  = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              send_valid, send_dual;
  logic [4:0]        send_port_a, send_port_b;
  logic [W-1:0]      send_data_a, send_data_b;
  logic              send_stall;
  logic              recv_valid, recv_pair;
  logic [4:0]        recv_port_a, recv_port_b, recv_tag;
  logic              recv_stall, rd_wen, st_en;
  logic [4:0]        rd_tag;
  logic [W-1:0]      rd_data, st_addr;
  logic [NI-1:0]     fab_in_valid, fab_in_ready;
  logic [NI*W-1:0]   fab_in_data;
  logic [NO-1:0]     fab_out_valid, fab_out_ready;
  logic [NO*W-1:0]   fab_out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] mi [NI][$];
  logic [W-1:0] mo [NO][$];

  always #4 clk = ~clk;

  accel_port_bridge #(.NUM_IN(NI), .NUM_OUT(NO), .DEPTH(D)) u_accel_port_bridge (
    .clk(clk), .rst_n(rst_n),
    .send_valid(send_valid), .send_dual(send_dual),
    .send_port_a(send_port_a), .send_port_b(send_port_b),
    .send_data_a(send_data_a), .send_data_b(send_data_b), .send_stall(send_stall),
    .recv_valid(recv_valid), .recv_pair(recv_pair),
    .recv_port_a(recv_port_a), .recv_port_b(recv_port_b), .recv_tag(recv_tag),
    .recv_stall(recv_stall), .rd_wen(rd_wen), .rd_tag(rd_tag), .rd_data(rd_data),
    .st_en(st_en), .st_addr(st_addr),
    .fab_in_valid(fab_in_valid), .fab_in_ready(fab_in_ready), .fab_in_data(fab_in_data),
    .fab_out_valid(fab_out_valid), .fab_out_ready(fab_out_ready), .fab_out_data(fab_out_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic drive(input int span, input int send_pct, input int dual_pct,
                       input int recv_pct, input int pair_pct,
                       input int inrdy_pct, input int outval_pct);
    send_valid  = ($urandom_range(99, 0) < send_pct);
    send_dual   = ($urandom_range(99, 0) < dual_pct);
    send_port_a = 5'($urandom_range(span - 1, 0));
    send_port_b = 5'($urandom_range(span - 1, 0));
    send_data_a = rnd64();
    send_data_b = rnd64();
    recv_valid  = ($urandom_range(99, 0) < recv_pct);
    recv_pair   = ($urandom_range(99, 0) < pair_pct);
    recv_port_a = 5'($urandom_range(span - 1, 0));
    recv_port_b = 5'($urandom_range(span - 1, 0));
    recv_tag    = 5'($urandom_range(31, 0));
    for (int i = 0; i < NI; i++) fab_in_ready[i] = ($urandom_range(99, 0) < inrdy_pct);
    for (int o = 0; o < NO; o++) begin
      fab_out_valid[o] = ($urandom_range(99, 0) < outval_pct);
      fab_out_data[o*W +: W] = rnd64();
    end
  endtask

  task automatic step();
    int  sz_in [NI];
    int  sz_out [NO];
    bit  aok, bon, same, ok, ra, rb, rsame, avail, rgo;
    string stag, rtag;
    logic [W-1:0] exp_data, exp_addr;
    #1;
    for (int i = 0; i < NI; i++) begin
      sz_in[i] = mi[i].size();
      chk("R10", "fab_in_valid", W'(fab_in_valid[i]), W'(sz_in[i] != 0));
      if (sz_in[i] != 0) chk("R2", "fab_in_data", fab_in_data[i*W +: W], mi[i][0]);
    end
    for (int o = 0; o < NO; o++) begin
      sz_out[o] = mo[o].size();
      chk("R10", "fab_out_ready", W'(fab_out_ready[o]), W'(sz_out[o] < D));
    end

    aok  = send_port_a < NI;
    bon  = send_dual && (send_port_b < NI);
    same = aok && bon && (send_port_a == send_port_b);
    if (same) ok = sz_in[send_port_a] <= D - 2;
    else begin
      ok = 1'b1;
      if (aok && sz_in[send_port_a] >= D) ok = 1'b0;
      if (bon && sz_in[send_port_b] >= D) ok = 1'b0;
    end
    if (same) stag = "R5";
    else if (!aok || (send_dual && !bon)) stag = "R9";
    else if (send_dual) stag = "R3";
    else stag = "R4";
    chk(stag, "send_stall", W'(send_stall), W'(send_valid && !ok));

    ra    = recv_port_a < NO;
    rb    = recv_pair && (recv_port_b < NO);
    rsame = ra && rb && (recv_port_a == recv_port_b);
    if (rsame) avail = sz_out[recv_port_a] >= 2;
    else begin
      avail = 1'b1;
      if (ra && sz_out[recv_port_a] == 0) avail = 1'b0;
      if (rb && sz_out[recv_port_b] == 0) avail = 1'b0;
    end
    rgo = recv_valid && avail;
    if (!ra || (recv_pair && !rb)) rtag = "R9";
    else if (recv_pair) rtag = "R8";
    else rtag = "R6";
    chk(rtag, "recv_stall", W'(recv_stall), W'(recv_valid && !avail));
    chk("R7", "rd_wen", W'(rd_wen), W'(rgo && !recv_pair));
    chk("R8", "st_en", W'(st_en), W'(rgo && recv_pair));
    exp_data = ra ? mo[recv_port_a][0] : '0;
    exp_addr = '0;
    if (rb) exp_addr = rsame ? mo[recv_port_b][1] : mo[recv_port_b][0];
    if (rgo) begin
      chk(ra ? (recv_pair ? "R8" : "R7") : "R9", "rd_data", rd_data, exp_data);
      if (!recv_pair) chk("R7", "rd_tag", W'(rd_tag), W'(recv_tag));
      else chk(rb ? "R8" : "R9", "st_addr", st_addr, exp_addr);
    end

    for (int i = 0; i < NI; i++)
      if (fab_in_ready[i] && sz_in[i] != 0) void'(mi[i].pop_front());
    if (send_valid && ok) begin
      if (aok) mi[send_port_a].push_back(send_data_a);
      if (bon) mi[send_port_b].push_back(send_data_b);
    end
    if (rgo) begin
      if (ra) void'(mo[recv_port_a].pop_front());
      if (rb) void'(mo[recv_port_b].pop_front());
    end
    for (int o = 0; o < NO; o++)
      if (fab_out_valid[o] && sz_out[o] < D) mo[o].push_back(fab_out_data[o*W +: W]);
    @(negedge clk);
  endtask

  task automatic run_phase(input int n, input int span, input int send_pct,
                           input int dual_pct, input int recv_pct, input int pair_pct,
                           input int inrdy_pct, input int outval_pct);
    for (int c = 0; c < n; c++) begin
      drive(span, send_pct, dual_pct, recv_pct, pair_pct, inrdy_pct, outval_pct);
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    send_valid = 0; send_dual = 0; send_port_a = 0; send_port_b = 0;
    send_data_a = 0; send_data_b = 0;
    recv_valid = 0; recv_pair = 0; recv_port_a = 0; recv_port_b = 0; recv_tag = 0;
    fab_in_ready = '0; fab_out_valid = '0; fab_out_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "fab_in_valid", W'(fab_in_valid), '0);
    chk("R1", "fab_out_ready", W'(fab_out_ready), W'({NO{1'b1}}));
    chk("R1", "send_stall", W'(send_stall), '0);
    chk("R1", "recv_stall", W'(recv_stall), '0);

    // fill input FIFOs on few ports: full and same-port dual stalls (R4, R5)
    run_phase(80, 4, 70, 50, 0, 0, 0, 0);
    // drain with sends still arriving (R2, R3)
    run_phase(200, 8, 60, 40, 0, 0, 50, 0);
    // fill output FIFOs with no receives (R10)
    run_phase(20, 8, 0, 0, 0, 0, 100, 80);
    // receives including pairs and out-of-range ports (R6, R7, R8, R9)
    run_phase(300, 10, 30, 40, 70, 50, 40, 20);
    // pairs concentrated on few ports (R8 same-port)
    run_phase(300, 3, 40, 50, 60, 70, 50, 50);
    // broad mix
    run_phase(4000, 10, 50, 40, 50, 30, 50, 50);
    // final drain
    run_phase(100, 8, 0, 0, 80, 0, 100, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule